// File: doc/BRIEF.md
# Processor Status and Exception Return Unit

This block keeps a 32-bit processor status word, an exception-cause register, a debug register and three saved return addresses: one for ordinary exceptions, one for non-maskable interrupts and one for debug mode. A decoder outside the block presents one command per cycle, with a 2-bit immediate. The block then applies the state change for that command: it can disable or enable interrupts, return from an exception, raise a software interrupt, return from debug mode, or flag a debug breakpoint.

Commands that redirect the program counter produce a new-PC value with a one-cycle valid strobe. There are two such commands: the exception return and the debug return. The exception-entry logic lives elsewhere. It writes any of the six registers through a single load port, which is a select code plus a data word. All register contents are visible on the outputs at all times.

Top module: `status_ret_unit`

## Requirements
- R1: When reset is asserted (active low, asynchronous), every register clears to zero. This covers the status word, the cause register, the debug register, the three saved PCs and the new-PC output. The valid strobe is low during reset.
- R2: Command code 1 clears status bit 0, the current interrupt enable. Command code 2 sets status bit 0. Neither command changes any other bit, and issuing either one again leaves the word unchanged.
- R3: Command code 3 is the exception return. When status bit 9, the NMI flag, is 1, the new PC equals the NMI saved PC with bit 0 forced to 0. In that case only bit 9 of the status word changes, and it becomes 0.
- R4: When command code 3 is issued with status bit 9 at 0, the new PC equals the exception saved PC with bit 0 forced to 0. Status bit 2 takes the old value of bit 3, and status bit 0 takes the old value of bit 1. All other status bits are kept.
- R5: Command code 4 with immediate n (0 to 3) sets bit 4+n of the cause register and leaves every other bit alone. Repeating it changes nothing.
- R6: Command code 5 drives the new PC with the debug saved PC unchanged. It also clears bit 14 of the debug register, the debug-mode bit.
- R7: Command code 6 sets bit 1 of the debug register, the breakpoint-pending bit, and changes no other bit. Repeating it changes nothing.
- R8: The new-PC valid output is high for exactly the one cycle that follows each clock edge accepting command code 3 or 5. It never rises for any other command.
- R9: The load port writes ldData at the clock edge into the register chosen by ldSel. The codes are 0 status, 1 cause, 2 debug, 3 exception PC, 4 NMI PC and 5 debug PC. Select codes 6 and 7 write nothing.
- R10: A load requested in the same cycle as a valid command is dropped, and the command is carried out.
- R11: Command codes 0 and 7 change nothing. When cmdValid is low, every command code is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command code |
| cmdImm | input | 2 | Software-interrupt number |
| ldEn | input | 1 | Register load request |
| ldSel | input | 3 | Register chosen for the load |
| ldData | input | 32 | Value to load |
| newPc | output | 32 | Redirect target |
| newPcValid | output | 1 | Redirect strobe, one cycle |
| statusWord | output | 32 | Processor status word |
| causeReg | output | 32 | Exception-cause register |
| debugReg | output | 32 | Debug register |
| excPc | output | 32 | Exception return address |
| nmiPc | output | 32 | NMI return address |
| dbgPc | output | 32 | Debug return address |

## Verification
Every result of a command or a load passes through exactly one register. It is therefore visible in the cycle right after the accepting edge: the register outputs, the new PC and the rising valid strobe all appear then. The bench drives each stimulus at a falling edge and reads the outputs at the next falling edge. That places each read after the single edge that carries the result. For each redirect, the bench reads one more falling edge later to confirm that the strobe has dropped again after one cycle.

// File: rtl/status_ret_pkg.sv
package status_ret_pkg;
  localparam int IecBit     = 0;
  localparam int IepBit     = 1;
  localparam int UmcBit     = 2;
  localparam int UmpBit     = 3;
  localparam int NmiBit     = 9;
  localparam int SwiBase    = 4;
  localparam int SwiCount   = 4;
  localparam int SwiIdxW    = $clog2(SwiCount);
  localparam int DbgModeBit = 14;
  localparam int DbgBrkBit  = 1;
  localparam int NumLdRegs  = 6;

  typedef enum logic [2:0] {
    CmdNop    = 3'd0,
    CmdIntDis = 3'd1,
    CmdIntEn  = 3'd2,
    CmdExcRet = 3'd3,
    CmdSwInt  = 3'd4,
    CmdDbgRet = 3'd5,
    CmdDbgBrk = 3'd6,
    CmdRsvd   = 3'd7
  } cmd_e;

  typedef struct packed {
    logic                 intDis;
    logic                 intEn;
    logic                 excRet;
    logic                 swInt;
    logic [SwiIdxW-1:0]   swIdx;
    logic                 dbgRet;
    logic                 dbgBrk;
    logic [NumLdRegs-1:0] ldOneHot;
  } strobe_t;
endpackage

// File: rtl/status_ret_ctrl.sv
module status_ret_ctrl
  import status_ret_pkg::*;
(
  input  logic                          cmdValid,
  input  logic [2:0]                    cmdOp,
  input  logic [SwiIdxW-1:0]            cmdImm,
  input  logic                          ldEn,
  input  logic [$clog2(NumLdRegs+2)-1:0] ldSel,
  output strobe_t                       strobes
);
  localparam int SelW = $clog2(NumLdRegs + 2);

  logic [NumLdRegs-1:0] ldHit;

  // One decode line per loadable register.
  for (genvar g = 0; g < NumLdRegs; g++) begin : g_ld
    assign ldHit[g] = ldEn && (ldSel == SelW'(g));
  end

  always_comb begin
    strobes = '0;
    if (cmdValid) begin
      // A valid command owns the cycle; any load request is dropped.
      unique case (cmd_e'(cmdOp))
        CmdIntDis: strobes.intDis = 1'b1;
        CmdIntEn:  strobes.intEn  = 1'b1;
        CmdExcRet: strobes.excRet = 1'b1;
        CmdSwInt: begin
          strobes.swInt = 1'b1;
          strobes.swIdx = cmdImm;
        end
        CmdDbgRet: strobes.dbgRet = 1'b1;
        CmdDbgBrk: strobes.dbgBrk = 1'b1;
        default:   ;
      endcase
    end else begin
      strobes.ldOneHot = ldHit;
    end
  end
endmodule

// File: rtl/status_ret_dpath.sv
module status_ret_dpath
  import status_ret_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [DataW-1:0] ldData,
  output logic [DataW-1:0] newPc,
  output logic             newPcValid,
  output logic [DataW-1:0] statusWord,
  output logic [DataW-1:0] causeReg,
  output logic [DataW-1:0] debugReg,
  output logic [DataW-1:0] excPc,
  output logic [DataW-1:0] nmiPc,
  output logic [DataW-1:0] dbgPc
);
  localparam logic [DataW-1:0] PcMask = {{(DataW-1){1'b1}}, 1'b0};

  logic [DataW-1:0] statusQ, statusD;
  logic [DataW-1:0] causeQ,  causeD;
  logic [DataW-1:0] debugQ,  debugD;
  logic [DataW-1:0] epcQ, npcQ, depcQ;
  logic [DataW-1:0] newPcQ, newPcD;
  logic             newPcValidQ;
  logic [SwiCount-1:0] swiSel;
  logic [DataW-1:0] swiMask;

  // One set-line per software-interrupt number.
  for (genvar g = 0; g < SwiCount; g++) begin : g_swi
    assign swiSel[g] = strobes.swInt && (strobes.swIdx == SwiIdxW'(g));
  end

  always_comb begin
    swiMask = '0;
    swiMask[SwiBase +: SwiCount] = swiSel;
  end

  always_comb begin
    statusD = strobes.ldOneHot[0] ? ldData : statusQ;
    if (strobes.intDis) statusD[IecBit] = 1'b0;
    if (strobes.intEn)  statusD[IecBit] = 1'b1;
    if (strobes.excRet) begin
      if (statusQ[NmiBit]) begin
        statusD[NmiBit] = 1'b0;
      end else begin
        statusD[UmcBit] = statusQ[UmpBit];
        statusD[IecBit] = statusQ[IepBit];
      end
    end
  end

  always_comb begin
    causeD = strobes.ldOneHot[1] ? ldData : (causeQ | swiMask);
  end

  always_comb begin
    debugD = strobes.ldOneHot[2] ? ldData : debugQ;
    if (strobes.dbgRet) debugD[DbgModeBit] = 1'b0;
    if (strobes.dbgBrk) debugD[DbgBrkBit]  = 1'b1;
  end

  always_comb begin
    newPcD = newPcQ;
    if (strobes.excRet) newPcD = (statusQ[NmiBit] ? npcQ : epcQ) & PcMask;
    if (strobes.dbgRet) newPcD = depcQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ     <= '0;
      causeQ      <= '0;
      debugQ      <= '0;
      epcQ        <= '0;
      npcQ        <= '0;
      depcQ       <= '0;
      newPcQ      <= '0;
      newPcValidQ <= 1'b0;
    end else begin
      statusQ     <= statusD;
      causeQ      <= causeD;
      debugQ      <= debugD;
      if (strobes.ldOneHot[3]) epcQ  <= ldData;
      if (strobes.ldOneHot[4]) npcQ  <= ldData;
      if (strobes.ldOneHot[5]) depcQ <= ldData;
      newPcQ      <= newPcD;
      newPcValidQ <= strobes.excRet || strobes.dbgRet;
    end
  end

  assign newPc      = newPcQ;
  assign newPcValid = newPcValidQ;
  assign statusWord = statusQ;
  assign causeReg   = causeQ;
  assign debugReg   = debugQ;
  assign excPc      = epcQ;
  assign nmiPc      = npcQ;
  assign dbgPc      = depcQ;

  p_int_dis_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.intDis |=> !statusQ[IecBit]);
  p_int_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.intEn |=> statusQ[IecBit]);
  p_nmi_ret_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.excRet && statusQ[NmiBit]) |=>
      (!statusQ[NmiBit] && newPcQ == ($past(npcQ) & PcMask)));
  p_exc_ret_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.excRet && !statusQ[NmiBit]) |=>
      (statusQ[UmcBit] == $past(statusQ[UmpBit]) &&
       statusQ[IecBit] == $past(statusQ[IepBit]) &&
       newPcQ == ($past(epcQ) & PcMask)));
  p_swi_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swInt |=> causeQ[SwiBase + int'($past(strobes.swIdx))]);
  p_dbg_ret_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dbgRet |=> (!debugQ[DbgModeBit] && newPcQ == $past(depcQ)));
  p_dbg_brk_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dbgBrk |=> debugQ[DbgBrkBit]);
  p_valid_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    newPcValidQ |-> $past(strobes.excRet || strobes.dbgRet));
  p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.intDis || strobes.intEn || strobes.swInt || strobes.dbgBrk) |=> !newPcValidQ);
endmodule

// File: rtl/status_ret_unit.sv
module status_ret_unit
  import status_ret_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [1:0]       cmdImm,
  input  logic             ldEn,
  input  logic [2:0]       ldSel,
  input  logic [DataW-1:0] ldData,
  output logic [DataW-1:0] newPc,
  output logic             newPcValid,
  output logic [DataW-1:0] statusWord,
  output logic [DataW-1:0] causeReg,
  output logic [DataW-1:0] debugReg,
  output logic [DataW-1:0] excPc,
  output logic [DataW-1:0] nmiPc,
  output logic [DataW-1:0] dbgPc
);
  strobe_t strobes;

  status_ret_ctrl i_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdImm   (cmdImm),
    .ldEn     (ldEn),
    .ldSel    (ldSel),
    .strobes  (strobes)
  );

  status_ret_dpath #(.DataW(DataW)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ldData     (ldData),
    .newPc      (newPc),
    .newPcValid (newPcValid),
    .statusWord (statusWord),
    .causeReg   (causeReg),
    .debugReg   (debugReg),
    .excPc      (excPc),
    .nmiPc      (nmiPc),
    .dbgPc      (dbgPc)
  );
endmodule

// File: tb/test_status_ret_unit.sv
module test_status_ret_unit;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [1:0]  cmdImm = 2'd0;
  logic        ldEn = 1'b0;
  logic [2:0]  ldSel = 3'd0;
  logic [31:0] ldData = '0;
  logic [31:0] newPc, statusWord, causeReg, debugReg, excPc, nmiPc, dbgPc;
  logic        newPcValid;

  int checks = 0;
  int failures = 0;

  always #(ClkPeriod/2) clk = ~clk;

  status_ret_unit i_status_ret_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdImm(cmdImm),
    .ldEn(ldEn), .ldSel(ldSel), .ldData(ldData), .newPc(newPc),
    .newPcValid(newPcValid), .statusWord(statusWord), .causeReg(causeReg),
    .debugReg(debugReg), .excPc(excPc), .nmiPc(nmiPc), .dbgPc(dbgPc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Load presented at a falling edge, written at the next rising edge.
  task automatic doLoad(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    ldEn = 1'b1; ldSel = sel; ldData = data;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  // Command presented at a falling edge; results readable on return.
  task automatic doCmd(input logic [2:0] op, input logic [1:0] imm);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdImm = imm;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0; cmdImm = 2'd0;
  endtask

  task automatic testReset();
    chk("R1 status", statusWord, 32'h0);
    chk("R1 cause", causeReg, 32'h0);
    chk("R1 debug", debugReg, 32'h0);
    chk("R1 pcs", excPc | nmiPc | dbgPc, 32'h0);
    chk("R1 newPc", newPc, 32'h0);
    chk("R1 valid", {31'b0, newPcValid}, 32'h0);
  endtask

  task automatic testIntEnable();
    doLoad(3'd0, 32'h0000_0002);
    doCmd(3'd2, 2'd0);
    chk("R2 enable", statusWord, 32'h0000_0003);
    chk("R8 no strobe on enable", {31'b0, newPcValid}, 32'h0);
    doCmd(3'd2, 2'd0);
    chk("R2 enable again", statusWord, 32'h0000_0003);
    doCmd(3'd1, 2'd0);
    chk("R2 disable", statusWord, 32'h0000_0002);
    doCmd(3'd1, 2'd0);
    chk("R2 disable again", statusWord, 32'h0000_0002);
  endtask

  task automatic testExcReturn();
    doLoad(3'd3, 32'h1000_0123);
    doLoad(3'd4, 32'h7777_7777);
    doLoad(3'd0, 32'h0000_0089);
    doCmd(3'd3, 2'd0);
    chk("R4 newPc", newPc, 32'h1000_0122);
    chk("R8 strobe high", {31'b0, newPcValid}, 32'h1);
    chk("R4 status copy", statusWord, 32'h0000_008C);
    @(negedge clk);
    chk("R8 strobe one cycle", {31'b0, newPcValid}, 32'h0);
    doLoad(3'd0, 32'h0000_0006);
    doCmd(3'd3, 2'd0);
    chk("R4 status copy second", statusWord, 32'h0000_0003);
    // back-to-back redirects: strobe stays high for each
    doLoad(3'd0, 32'h0000_0000);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd3;
    @(negedge clk);
    chk("R8 first of pair", {31'b0, newPcValid}, 32'h1);
    cmdOp = 3'd5;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0;
    chk("R8 second of pair", {31'b0, newPcValid}, 32'h1);
    @(negedge clk);
    chk("R8 pair ends", {31'b0, newPcValid}, 32'h0);
  endtask

  task automatic testNmiReturn();
    doLoad(3'd4, 32'h2000_0005);
    doLoad(3'd3, 32'h5555_5555);
    doLoad(3'd0, 32'h0000_020A);
    doCmd(3'd3, 2'd0);
    chk("R3 newPc", newPc, 32'h2000_0004);
    chk("R3 status", statusWord, 32'h0000_000A);
    chk("R8 strobe nmi", {31'b0, newPcValid}, 32'h1);
  endtask

  task automatic testSoftInt();
    doLoad(3'd1, 32'h0000_0001);
    doCmd(3'd4, 2'd2);
    chk("R5 imm2", causeReg, 32'h0000_0041);
    doCmd(3'd4, 2'd2);
    chk("R5 imm2 again", causeReg, 32'h0000_0041);
    doCmd(3'd4, 2'd0);
    chk("R5 imm0", causeReg, 32'h0000_0051);
    doCmd(3'd4, 2'd3);
    chk("R5 imm3", causeReg, 32'h0000_00D1);
    doCmd(3'd4, 2'd1);
    chk("R5 imm1", causeReg, 32'h0000_00F1);
    chk("R8 no strobe swi", {31'b0, newPcValid}, 32'h0);
  endtask

  task automatic testDebug();
    doLoad(3'd2, 32'hFFFF_FFFF);
    doLoad(3'd5, 32'h3000_0007);
    doCmd(3'd5, 2'd0);
    chk("R6 newPc", newPc, 32'h3000_0007);
    chk("R6 debug", debugReg, 32'hFFFF_BFFF);
    chk("R8 strobe dbg", {31'b0, newPcValid}, 32'h1);
    doLoad(3'd2, 32'h0000_0000);
    doCmd(3'd6, 2'd0);
    chk("R7 break", debugReg, 32'h0000_0002);
    chk("R8 no strobe brk", {31'b0, newPcValid}, 32'h0);
    doCmd(3'd6, 2'd0);
    chk("R7 break again", debugReg, 32'h0000_0002);
  endtask

  task automatic testIgnored();
    doLoad(3'd0, 32'h0000_0209);
    doCmd(3'd0, 2'd0);
    chk("R11 op0", statusWord, 32'h0000_0209);
    doCmd(3'd7, 2'd3);
    chk("R11 op7 status", statusWord, 32'h0000_0209);
    chk("R11 op7 valid", {31'b0, newPcValid}, 32'h0);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd3;
    @(negedge clk);
    cmdOp = 3'd0;
    chk("R11 valid low status", statusWord, 32'h0000_0209);
    chk("R11 valid low strobe", {31'b0, newPcValid}, 32'h0);
  endtask

  task automatic testLoadRules();
    doLoad(3'd3, 32'hAAAA_0000);
    chk("R9 excPc", excPc, 32'hAAAA_0000);
    doLoad(3'd4, 32'hBBBB_0000);
    chk("R9 nmiPc", nmiPc, 32'hBBBB_0000);
    doLoad(3'd6, 32'h1234_5678);
    doLoad(3'd7, 32'h1234_5678);
    chk("R9 sel6/7 status", statusWord, 32'h0000_0209);
    chk("R9 sel6/7 cause", causeReg, 32'h0000_00F1);
    chk("R9 sel6/7 debug", debugReg, 32'h0000_0002);
    chk("R9 sel6/7 pcs", {excPc[31:16], nmiPc[31:16]}, 32'hAAAA_BBBB);
    chk("R9 sel6/7 dbgPc", dbgPc, 32'h3000_0007);
    // load and command together: load dropped, command applied
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd2;
    ldEn = 1'b1; ldSel = 3'd0; ldData = 32'hFFFF_0000;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0; ldEn = 1'b0;
    chk("R10 load dropped", statusWord, 32'h0000_0209);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd1;
    ldEn = 1'b1; ldSel = 3'd5; ldData = 32'h0BAD_0000;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0; ldEn = 1'b0;
    chk("R10 command applied", statusWord, 32'h0000_0208);
    chk("R10 pc load dropped", dbgPc, 32'h3000_0007);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testIntEnable();
    testExcReturn();
    testNmiReturn();
    testSoftInt();
    testDebug();
    testIgnored();
    testLoadRules();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule